// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port (Master)

This block is a master-mode stereo audio serial port. It divides the system clock down to a bit clock and drives a frame clock. In the same frames it shifts a left/right sample pair out on the serial data output and assembles a pair from the serial data input. Every frame is 64 bit clocks long. A run-time setting chooses one of four framings: I2S, left-justified, right-justified, or a PCM/DSP mode. In PCM mode a single-bit start pulse replaces the channel-select level, and the two channels sit back to back with zero fill after them.

Transmit samples enter through a valid/ready handshake, one pair per frame. A received pair leaves with a one-cycle valid strobe. The settings are sampled once per frame, so software may rewrite them at any time without corrupting the frame in progress. Sample words are right-aligned in 32 bits on both sides.

Top module: `aud_serial_port`

## Requirements
- R1: The bit clock period is `cfg_div` system cycles, with odd values rounded down and values below 2 treated as 2. With `cfg_bclk_inv`=0, `sdout_o` and `fclk_o` change only on falling edges of `bclk_o` and `sdin_i` is sampled on rising edges. With `cfg_bclk_inv`=1 the two edges swap roles.
- R2: A frame is 64 bit clocks. Each channel is sent MSB first. `cfg_len` selects the sample length: 0 is 32 bits, 1 is 24, 2 is 20 and 3 is 16. Sample words are right-aligned, and bits above the length are ignored.
- R3: With `cfg_fmt`=0 (I2S), the left MSB is in slot 0 and the right MSB is in slot 32. The frame clock takes each channel's level one bit clock before that channel's MSB, in slots 63 and 31. Unused slots carry 0.
- R4: With `cfg_fmt`=1 (left-justified), the data is placed as in R3. The frame clock shows left in slots 0–31 and right in slots 32–63, so it changes in the same bit clock as each MSB.
- R5: With `cfg_fmt`=2 (right-justified), each channel's LSB is in the last slot of its half (slots 31 and 63). The slots before each MSB carry 0. The frame clock behaves as in R4.
- R6: For formats 0–2, `cfg_lr_pol`=0 makes a low frame clock mark the left channel, and `cfg_lr_pol`=1 makes a high frame clock mark it.
- R7: With `cfg_fmt`=3 (PCM), the left MSB is in slot 0 and the right MSB is in the slot right after the left LSB. All later slots carry 0. The frame clock is high for exactly one bit clock per frame: slot 0 when `cfg_pcm_early`=0, and slot 63 (the bit clock just before the next left MSB) when `cfg_pcm_early`=1. `cfg_lr_pol` has no effect in this mode.
- R8: `tx_ready` is a one-cycle pulse at each frame start, and a pair is taken when `tx_valid` is high during that pulse. If `tx_valid` is low, the frame sends zeros and `tx_underrun` rises and stays high until reset.
- R9: After the last slot of each frame is sampled, `rx_valid` pulses for one cycle. `rx_left`/`rx_right` then hold the words received in that frame, right-aligned, with the upper bits zero.
- R10: All configuration inputs are taken only at a frame start. A change in mid-frame does not alter the frame in progress.
- R11: During reset, `bclk_o`=1 (with `cfg_bclk_inv`=0), and `fclk_o`, `sdout_o`, `tx_ready`, `rx_valid` and `tx_underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 PCM |
| cfg_len | input | 2 | Sample length code (32/24/20/16 bits) |
| cfg_bclk_inv | input | 1 | Swap launch and sample edges of the bit clock |
| cfg_lr_pol | input | 1 | Frame clock level that marks the left channel |
| cfg_pcm_early | input | 1 | PCM start pulse one bit clock before the left MSB |
| cfg_div | input | DIV_W | Bit clock divisor in system cycles |
| tx_valid | input | 1 | Transmit pair available |
| tx_ready | output | 1 | Frame start: transmit pair taken |
| tx_left | input | 32 | Left transmit sample, right-aligned |
| tx_right | input | 32 | Right transmit sample, right-aligned |
| tx_underrun | output | 1 | Sticky: a frame started without a transmit pair |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock / start pulse |
| sdout_o | output | 1 | Serial data out |
| sdin_i | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle strobe: received pair ready |
| rx_left | output | 32 | Received left sample, right-aligned |
| rx_right | output | 32 | Received right sample, right-aligned |

## Verification
The hardest case to reach is a configuration change in mid-frame. It must leave the current frame intact and apply from the next frame start, and that can only be seen by comparing the frame in flight with the one after it. The bench loops serial out back to serial in. It rewrites format and length about forty cycles into a frame, then checks every slot of both frames against the settings captured at each `tx_ready` pulse, along with the matching received pairs. Underrun is forced by withholding `tx_valid` for exactly one frame start. After that the bench expects a zero pair and a flag that stays set.

// File: rtl/aud_serial_port.sv
`timescale 1ns/1ps
module aud_serial_port #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_fmt,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_lr_pol,
  input  logic             cfg_pcm_early,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [31:0]      tx_left,
  input  logic [31:0]      tx_right,
  output logic             tx_underrun,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             sdout_o,
  input  logic             sdin_i,
  output logic             rx_valid,
  output logic [31:0]      rx_left,
  output logic [31:0]      rx_right
);

  localparam int HW = DIV_W - 1;
  localparam logic [5:0] LAST = 6'd63;
  localparam logic [1:0] F_RJ = 2'd2;
  localparam logic [1:0] F_PCM = 2'd3;

  typedef struct packed {
    logic [1:0]       fmt;
    logic [1:0]       len;
    logic             inv;
    logic             pol;
    logic             early;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic logic [20:0] bounds(input logic [1:0] f, input logic [1:0] lc);
    logic [6:0] n, ls, rs;
    case (lc)
      2'd0: n = 7'd32;
      2'd1: n = 7'd24;
      2'd2: n = 7'd20;
      default: n = 7'd16;
    endcase
    ls = (f == F_RJ) ? 7'd32 - n : 7'd0;
    rs = (f == F_PCM) ? n : (f == F_RJ) ? 7'd64 - n : 7'd32;
    return {n, ls, rs};
  endfunction

  function automatic logic [1:0] hit(input logic [1:0] f, input logic [1:0] lc, input logic [5:0] p);
    logic [6:0] n, ls, rs, pp;
    {n, ls, rs} = bounds(f, lc);
    pp = {1'b0, p};
    return {(pp >= ls) && (pp < ls + n), (pp >= rs) && (pp < rs + n)};
  endfunction

  function automatic logic [4:0] bit_idx(input logic [1:0] f, input logic [1:0] lc, input logic [5:0] p);
    logic [6:0] n, ls, rs, pp, off;
    {n, ls, rs} = bounds(f, lc);
    pp = {1'b0, p};
    off = ((pp >= ls) && (pp < ls + n)) ? pp - ls : pp - rs;
    return 5'(n - 7'd1 - off);
  endfunction

  function automatic logic fclk_of(input logic [1:0] f, input logic pol, input logic early, input logic [5:0] p);
    logic [5:0] q;
    logic lft;
    q = p + 6'd1;
    if (f == F_PCM) return p == (early ? LAST : 6'd0);
    lft = (f == 2'd0) ? ~q[5] : ~p[5];
    return lft ? pol : ~pol;
  endfunction

  cfg_t cfg_in, act;
  logic [HW-1:0] divc, half, half_m1;
  logic bclk_n, run, tick, launch, sample, frame_start;
  logic [5:0] pos, npos;
  logic [31:0] txl, txr, tl_eff, tr_eff, rx_l, rx_r, base_l, base_r, rxl_n, rxr_n;
  logic [1:0] e_fmt, e_len, tx_hit, rx_hit;
  logic e_pol, e_early, txbit, fclk_nxt;
  logic [4:0] tx_ix;

  assign cfg_in = {cfg_fmt, cfg_len, cfg_bclk_inv, cfg_lr_pol, cfg_pcm_early, cfg_div};
  assign half = act.div[DIV_W-1:1];
  assign half_m1 = (half == '0) ? '0 : half - HW'(1);
  assign tick = run && (divc == half_m1);
  assign launch = tick && bclk_n;
  assign sample = tick && !bclk_n;
  assign frame_start = launch && (pos == LAST);
  assign tx_ready = frame_start;
  assign npos = pos + 6'd1;
  assign bclk_o = bclk_n ^ act.inv;

  assign e_fmt = frame_start ? cfg_fmt : act.fmt;
  assign e_len = frame_start ? cfg_len : act.len;
  assign e_pol = frame_start ? cfg_lr_pol : act.pol;
  assign e_early = frame_start ? cfg_pcm_early : act.early;
  assign tl_eff = frame_start ? (tx_valid ? tx_left : '0) : txl;
  assign tr_eff = frame_start ? (tx_valid ? tx_right : '0) : txr;

  assign tx_hit = hit(e_fmt, e_len, npos);
  assign tx_ix = bit_idx(e_fmt, e_len, npos);
  assign txbit = tx_hit[1] ? tl_eff[tx_ix] : tx_hit[0] ? tr_eff[tx_ix] : 1'b0;
  assign fclk_nxt = fclk_of(e_fmt, e_pol, e_early, npos);

  assign rx_hit = hit(act.fmt, act.len, pos);
  assign base_l = (pos == 6'd0) ? '0 : rx_l;
  assign base_r = (pos == 6'd0) ? '0 : rx_r;
  assign rxl_n = rx_hit[1] ? {base_l[30:0], sdin_i} : base_l;
  assign rxr_n = rx_hit[0] ? {base_r[30:0], sdin_i} : base_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
      run <= 1'b0;
      divc <= '0;
      bclk_n <= 1'b1;
      pos <= LAST;
      txl <= '0;
      txr <= '0;
      sdout_o <= 1'b0;
      fclk_o <= 1'b0;
      tx_underrun <= 1'b0;
      rx_l <= '0;
      rx_r <= '0;
      rx_left <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!run || frame_start) act <= cfg_in;
      run <= 1'b1;
      if (run) divc <= tick ? '0 : divc + HW'(1);
      if (tick) bclk_n <= ~bclk_n;
      if (launch) begin
        pos <= npos;
        txl <= tl_eff;
        txr <= tr_eff;
        sdout_o <= txbit;
        fclk_o <= fclk_nxt;
        if (frame_start && !tx_valid) tx_underrun <= 1'b1;
      end
      if (sample) begin
        rx_l <= rxl_n;
        rx_r <= rxr_n;
        if (pos == LAST) begin
          rx_left <= rxl_n;
          rx_right <= rxr_n;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> tx_underrun);
  p_rx_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_rx_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(sample) && $past(pos) == LAST));
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_start) |=> $stable(act));
  p_pcm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act.fmt == F_PCM && fclk_o && launch && !frame_start) |=> !fclk_o);

endmodule

// File: tb/aud_serial_port_bench.sv
`timescale 1ns/1ps
module aud_serial_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_fmt = 0, cfg_len = 0;
  logic cfg_bclk_inv = 0, cfg_lr_pol = 0, cfg_pcm_early = 0;
  logic [7:0] cfg_div = 8'd2;
  logic tx_valid = 1'b1, tx_ready, tx_underrun;
  logic [31:0] tx_left = 0, tx_right = 0, rx_left, rx_right;
  logic bclk_o, fclk_o, sdout_o, rx_valid;
  int checks = 0, errors = 0, ready_cnt = 0;
  logic [63:0] exp_q[$];

  always #2.5 clk = ~clk;

  aud_serial_port #(.DIV_W(8)) u_aud_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_len(cfg_len),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_lr_pol(cfg_lr_pol), .cfg_pcm_early(cfg_pcm_early),
    .cfg_div(cfg_div), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left),
    .tx_right(tx_right), .tx_underrun(tx_underrun), .bclk_o(bclk_o), .fclk_o(fclk_o),
    .sdout_o(sdout_o), .sdin_i(sdout_o), .rx_valid(rx_valid), .rx_left(rx_left),
    .rx_right(rx_right));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int nbits(input logic [1:0] lc);
    return (lc == 0) ? 32 : (lc == 1) ? 24 : (lc == 2) ? 20 : 16;
  endfunction

  function automatic logic [31:0] mask(input logic [31:0] v, input logic [1:0] lc);
    return (nbits(lc) == 32) ? v : v & ((32'd1 << nbits(lc)) - 32'd1);
  endfunction

  // expected {fclk, data} in slot k, built from R3-R7
  function automatic logic [1:0] exp_slot(input logic [1:0] f, input logic [1:0] lc, input logic pol,
      input logic early, input logic [31:0] l, input logic [31:0] r, input int k);
    int n = nbits(lc);
    int ls = (f == 2) ? 32 - n : 0;
    int rs = (f == 3) ? n : (f == 2) ? 64 - n : 32;
    logic d = 1'b0, fc;
    bit lft;
    if (k >= ls && k < ls + n) d = l[n - 1 - (k - ls)];
    else if (k >= rs && k < rs + n) d = r[n - 1 - (k - rs)];
    if (f == 3) fc = (k == (early ? 63 : 0));
    else begin
      lft = (f == 0) ? (((k + 1) % 64) < 32) : (k < 32);
      fc = lft ? pol : ~pol;
    end
    return {fc, d};
  endfunction

  function automatic string req_of(input logic [1:0] f, input logic pol);
    if (f == 3) return "R7";
    if (pol) return "R6";
    return (f == 0) ? "R3" : (f == 1) ? "R4" : "R5";
  endfunction

  // driver: hands pairs over at each frame start and pushes expected receive items
  bit hold_off = 0;
  initial begin
    bit pend = 0;
    forever begin
      @(negedge clk);
      if (pend) begin
        tx_left = $urandom; tx_right = $urandom; pend = 0;
        tx_valid = !hold_off;
      end
      if (rst_n && tx_ready) begin
        ready_cnt++;
        if (tx_valid) exp_q.push_back({mask(tx_left, cfg_len), mask(tx_right, cfg_len)});
        else exp_q.push_back(64'd0);
        pend = 1;
      end
    end
  end

  // monitor: slot checks, edge discipline, receive scoreboard
  initial begin
    logic pin_prev = 1'b1, sd_prev = 1'b0;
    bit armed = 0;
    int k = 0, cyc = 0, last_s = 0, sdiv;
    logic [1:0] s_fmt = 0, s_len = 0;
    logic s_pol = 0, s_early = 0, s_inv = 0;
    logic [31:0] s_l = 0, s_r = 0;
    logic [63:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        armed = 0; pin_prev = bclk_o; sd_prev = sdout_o;
      end else begin
        bit s_edge = armed && (s_inv ? (pin_prev && !bclk_o) : (!pin_prev && bclk_o));
        bit l_edge = s_inv ? (!pin_prev && bclk_o) : (pin_prev && !bclk_o);
        if (armed && sdout_o !== sd_prev)
          check(l_edge, "R1", "sdout changed off launch edge", sdout_o, sd_prev);
        if (s_edge && k < 64) begin
          logic [1:0] x = exp_slot(s_fmt, s_len, s_pol, s_early, s_l, s_r, k);
          check({fclk_o, sdout_o} === x, req_of(s_fmt, s_pol), $sformatf("slot %0d {fclk,data}", k),
                {fclk_o, sdout_o}, x);
          if (k >= 1) check(cyc - last_s == sdiv, "R1", "bit clock period", cyc - last_s, sdiv);
          last_s = cyc; k++;
        end
        if (rx_valid) begin
          if (exp_q.size() == 0) check(0, "R9", "unexpected rx strobe", {rx_left, rx_right}, 0);
          else begin
            e = exp_q.pop_front();
            check({rx_left, rx_right} === e, "R9", "received pair", {rx_left, rx_right}, e);
          end
        end
        if (tx_ready) begin
          armed = 1; k = 0;
          s_fmt = cfg_fmt; s_len = cfg_len; s_pol = cfg_lr_pol; s_early = cfg_pcm_early;
          s_inv = cfg_bclk_inv; s_l = tx_valid ? tx_left : 0; s_r = tx_valid ? tx_right : 0;
          sdiv = (int'(cfg_div) < 2) ? 2 : (int'(cfg_div) & ~1);
        end
        pin_prev = bclk_o; sd_prev = sdout_o;
      end
    end
  end

  task automatic setup(input logic [1:0] f, input logic [1:0] lc, input logic inv,
                       input logic pol, input logic early, input logic [7:0] d);
    @(negedge clk);
    rst_n = 0; hold_off = 0; tx_valid = 1;
    cfg_fmt = f; cfg_len = lc; cfg_bclk_inv = inv; cfg_lr_pol = pol;
    cfg_pcm_early = early; cfg_div = d;
    tx_left = $urandom; tx_right = $urandom;
    repeat (3) @(negedge clk);
    exp_q.delete();
    rst_n = 1;
  endtask

  task automatic frames(input int n);
    int t = ready_cnt + n + 1;
    wait (ready_cnt >= t);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check(bclk_o === 1'b1, "R11", "bclk in reset", bclk_o, 1);
    check({fclk_o, sdout_o, tx_ready, rx_valid, tx_underrun} === 5'b0, "R11", "outputs in reset",
          {fclk_o, sdout_o, tx_ready, rx_valid, tx_underrun}, 0);

    setup(2'd0, 2'd0, 0, 0, 0, 8'd2); frames(3);            // R3, R2 full 32 bits
    setup(2'd1, 2'd1, 0, 1, 0, 8'd4); frames(3);            // R4, R6
    setup(2'd2, 2'd2, 0, 0, 0, 8'd6); frames(3);            // R5
    setup(2'd2, 2'd3, 1, 0, 0, 8'd2); frames(3);            // R1 inverted edges
    setup(2'd3, 2'd3, 0, 1, 0, 8'd4); frames(3);            // R7 pulse on MSB, pol ignored
    setup(2'd3, 2'd0, 1, 0, 1, 8'd3); frames(3);            // R7 early pulse, R1 odd divisor
    setup(2'd0, 2'd1, 0, 0, 0, 8'd1); frames(2);            // R1 divisor below 2
    check(tx_underrun === 1'b0, "R8", "no underrun while fed", tx_underrun, 0);

    // R8: one starved frame sends zeros and latches the flag
    setup(2'd0, 2'd3, 0, 0, 0, 8'd2); frames(1);
    hold_off = 1;
    wait (tx_valid == 1'b0);
    frames(0);
    hold_off = 0;
    frames(2);
    check(tx_underrun === 1'b1, "R8", "underrun flag sticky", tx_underrun, 1);

    // R10: mid-frame config rewrite takes effect only at the next frame start
    setup(2'd1, 2'd0, 0, 0, 0, 8'd2); frames(1);
    wait (tx_ready == 1'b1);
    repeat (40) @(negedge clk);
    cfg_fmt = 2'd2; cfg_len = 2'd3;
    frames(3);
    check(1'b1, "R10", "mid-frame rewrite sequence completed", 0, 0);
    check(exp_q.size() <= 1, "R9", "receive queue drained", exp_q.size(), 1);
    finish_run();
  end
endmodule